// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is the target side of a two-wire serial memory bus (I2C-style), oversampled by a fast system clock. The bus clock and data lines pass through synchronisers. Their edges are decoded into bit clocks and START and STOP events. A small protocol engine then walks through three phases: the device address byte, a two-byte word address, and data bytes. SDA is driven only through an open-drain pull-low enable. The memory behind it is an internal byte array.

A host writes by addressing the target with the read/write bit low and sending a word address, followed by one or more data bytes and a STOP. The data bytes are collected in a one-page staging buffer. The STOP starts a timed busy window. During that window the staged bytes are committed to the array, unless the protect pin is high. The target stays silent on the bus for the whole window, so a host can poll it until it answers again. Reads start at the internal address counter. That counter can be loaded first by a write phase that carries no data. Reads continue for as long as the host acknowledges each byte.

Parameters: `ADDR_W`, the array address width, default 11, giving 2048 bytes, and at most 14. `PAGE_W`, the page offset width, default 6, giving 64-byte pages. `BUSY_CYC`, the length of the busy window in system clocks, which must be at least 2**PAGE_W. `SYNC_STAGES`, the synchroniser depth, default 2. The bus pins carry no valid/ready stream; SDA pacing is set entirely by the host's SCL.

Top module: `serial_mem_target`

## Requirements
- R1: After reset, and whenever no transfer is addressed to the target, `sda_pull_o` is low.
- R2: The first byte after a START is the device byte. Bits 7:4 must be 4'b1010, bits 3:1 must equal `sel_i[2:0]`, and bit 0 selects read (1) or write (0). On a match the target pulls SDA low during the ninth clock. On any mismatch it never pulls SDA until the next START.
- R3: In a write, the two bytes after the device byte are the word address, most significant byte first. Only their low `ADDR_W` bits are used. Each byte is acknowledged.
- R4: Each data byte after the word address is acknowledged and stored at the current address. Only the low `PAGE_W` address bits then advance.
- R5: A STOP that follows at least one data byte starts a busy window of `BUSY_CYC` clocks. During the window the target ignores START, STOP and address bytes and never pulls SDA. Once the window ends, it acknowledges its address again.
- R6: Data bytes that run past the last byte of a page wrap to the first byte of the same page.
- R7: Only the bytes actually received are written to the array. Other bytes of the page keep their contents.
- R8: While `wp_i` is high during the busy window, the array is not changed. Bytes are still acknowledged.
- R9: A read outputs the byte at the address counter, most significant bit first, with each bit driven after an SCL fall. A write phase, a repeated START and a read device byte together form a random read.
- R10: When the host acknowledges a read byte, the counter advances and the next byte follows, wrapping from the last array address to 0. When the host does not acknowledge, the target releases SDA and waits for STOP or START.
- R11: A write that ends with STOP before any data byte only loads the address counter and starts no busy window.
- R12: `sda_pull_o` rises only in the clock after a detected SCL fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sel_i | input | 3 | Hardwired chip-select value compared with device byte bits 3:1 |
| wp_i | input | 1 | Write protect, high blocks array updates |
| sda_pull_o | output | 1 | Open-drain enable: high pulls SDA low |

## Verification
The bench targets page wrap-around and partial commits. A design that carried into the page bits would write the third byte of a run starting at offset 62 into the next page. A design that committed the whole buffer would overwrite the untouched offset 61. It polls immediately after a STOP and again after the window; a busy window that is too short or missing shows up as an early acknowledge. It also reads across the top of the array, where a counter confined to a page would return to the page start instead of address 0. A STOP that carries only an address must still allow an immediate current-address read; a design that entered the busy window for it would refuse that read.

// File: rtl/sm_pkg.sv
`timescale 1ns/1ps
package sm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } sm_state_e;

  localparam logic [3:0] DEV_TAG = 4'b1010;
endpackage

// File: rtl/sm_line_sync.sv
`timescale 1ns/1ps
module sm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int W = STAGES + 1;

  logic [W-1:0] scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[W-2:0], scl_i};
      sda_q <= {sda_q[W-2:0], sda_i};
    end
  end

  logic scl_now, scl_prev, sda_now, sda_prev;
  assign scl_now  = scl_q[W-2];
  assign scl_prev = scl_q[W-1];
  assign sda_now  = sda_q[W-2];
  assign sda_prev = sda_q[W-1];

  assign sda_o      = sda_now;
  assign scl_rise_o = scl_now & ~scl_prev;
  assign scl_fall_o = ~scl_now & scl_prev;
  assign start_o    = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_o     = scl_now & scl_prev & ~sda_prev & sda_now;
endmodule

// File: rtl/sm_page_buf.sv
`timescale 1ns/1ps
module sm_page_buf #(
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] wr_idx_i,
  input  logic [7:0]        wr_data_i,
  input  logic              go_i,
  output logic              we_o,
  output logic [PAGE_W-1:0] idx_o,
  output logic [7:0]        data_o
);
  localparam int SLOTS = 1 << PAGE_W;

  logic [7:0]        slot_q [SLOTS];
  logic [SLOTS-1:0]  vld_q;
  logic              run_q;
  logic [PAGE_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (wr_i) slot_q[wr_idx_i] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      run_q <= 1'b0;
      idx_q <= '0;
    end else begin
      if (go_i) begin
        run_q <= 1'b1;
        idx_q <= '0;
      end else if (run_q) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == PAGE_W'(SLOTS - 1)) begin
          run_q <= 1'b0;
          vld_q <= '0;
        end
      end
      if (clr_i) vld_q <= '0;
      if (wr_i)  vld_q[wr_idx_i] <= 1'b1;
    end
  end

  assign we_o   = run_q & vld_q[idx_q];
  assign idx_o  = idx_q;
  assign data_o = slot_q[idx_q];

  // R7
  buf_wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |-> !run_q);
endmodule

// File: rtl/sm_mem_array.sv
`timescale 1ns/1ps
module sm_mem_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cell_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cell_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = cell_q[raddr_i];
endmodule

// File: rtl/serial_mem_target.sv
`timescale 1ns/1ps
module serial_mem_target
  import sm_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 6,
  parameter int BUSY_CYC    = 1000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] sel_i,
  input  logic       wp_i,
  output logic       sda_pull_o
);
  localparam int BUSY_W = $clog2(BUSY_CYC + 1);

  logic sda_s, scl_rise, scl_fall, start_p, stop_p;

  sm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_p),
    .stop_o     (stop_p)
  );

  sm_state_e         state_q;
  logic [3:0]        bitcnt_q;
  logic              ack_q, pull_q, rd_q, hack_q, data_q;
  logic [7:0]        sh_q, ahi_q;
  logic [6:0]        tx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BUSY_W-1:0] busy_q;
  logic              busy;
  logic [7:0]        mem_rd;

  assign busy = (busy_q != '0);

  logic live, byte_end, buf_wr, buf_clr, commit_go;
  assign live      = !busy && !start_p && !stop_p && (state_q != ST_IDLE);
  assign byte_end  = live && scl_fall && !ack_q && (bitcnt_q == 4'd8);
  assign buf_wr    = byte_end && (state_q == ST_WDAT);
  assign buf_clr   = byte_end && (state_q == ST_ALO);
  assign commit_go = !busy && stop_p && data_q;

  logic              pb_we;
  logic [PAGE_W-1:0] pb_idx;
  logic [7:0]        pb_data;

  sm_page_buf #(.PAGE_W(PAGE_W)) u_page (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (buf_clr),
    .wr_i      (buf_wr),
    .wr_idx_i  (addr_q[PAGE_W-1:0]),
    .wr_data_i (sh_q),
    .go_i      (commit_go),
    .we_o      (pb_we),
    .idx_o     (pb_idx),
    .data_o    (pb_data)
  );

  sm_mem_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .we_i    (pb_we & ~wp_i),
    .waddr_i ({addr_q[ADDR_W-1:PAGE_W], pb_idx}),
    .wdata_i (pb_data),
    .raddr_i (addr_q),
    .rdata_o (mem_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      ack_q    <= 1'b0;
      pull_q   <= 1'b0;
      rd_q     <= 1'b0;
      hack_q   <= 1'b0;
      data_q   <= 1'b0;
      sh_q     <= '0;
      ahi_q    <= '0;
      tx_q     <= '0;
      addr_q   <= '0;
      busy_q   <= '0;
    end else begin
      if (busy) busy_q <= busy_q - 1'b1;
      if (busy) begin
        state_q <= ST_IDLE;
        pull_q  <= 1'b0;
      end else if (start_p) begin
        state_q  <= ST_DEV;
        bitcnt_q <= '0;
        ack_q    <= 1'b0;
        pull_q   <= 1'b0;
        data_q   <= 1'b0;
      end else if (stop_p) begin
        state_q <= ST_IDLE;
        ack_q   <= 1'b0;
        pull_q  <= 1'b0;
        data_q  <= 1'b0;
        if (data_q) busy_q <= BUSY_W'(BUSY_CYC);
      end else if (state_q != ST_IDLE) begin
        if (scl_rise) begin
          if (ack_q) hack_q <= ~sda_s;
          else begin
            bitcnt_q <= bitcnt_q + 1'b1;
            if (state_q != ST_RDAT) sh_q <= {sh_q[6:0], sda_s};
          end
        end else if (scl_fall) begin
          if (!ack_q && bitcnt_q == 4'd8) begin
            ack_q <= 1'b1;
            case (state_q)
              ST_DEV: begin
                if (sh_q[7:1] == {DEV_TAG, sel_i}) begin
                  pull_q <= 1'b1;
                  rd_q   <= sh_q[0];
                end else begin
                  pull_q  <= 1'b0;
                  state_q <= ST_IDLE;
                end
              end
              ST_AHI: begin
                ahi_q  <= sh_q;
                pull_q <= 1'b1;
              end
              ST_ALO: begin
                addr_q <= ADDR_W'({ahi_q, sh_q});
                pull_q <= 1'b1;
              end
              ST_WDAT: begin
                addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + 1'b1;
                data_q <= 1'b1;
                pull_q <= 1'b1;
              end
              ST_RDAT: begin
                addr_q <= addr_q + 1'b1;
                pull_q <= 1'b0;
              end
              default: pull_q <= 1'b0;
            endcase
          end else if (!ack_q && state_q == ST_RDAT) begin
            tx_q   <= {tx_q[5:0], 1'b0};
            pull_q <= ~tx_q[6];
          end else if (ack_q) begin
            ack_q    <= 1'b0;
            bitcnt_q <= '0;
            pull_q   <= 1'b0;
            case (state_q)
              ST_DEV: begin
                if (rd_q) begin
                  state_q <= ST_RDAT;
                  tx_q    <= mem_rd[6:0];
                  pull_q  <= ~mem_rd[7];
                end else begin
                  state_q <= ST_AHI;
                end
              end
              ST_AHI:  state_q <= ST_ALO;
              ST_ALO:  state_q <= ST_WDAT;
              ST_WDAT: state_q <= ST_WDAT;
              ST_RDAT: begin
                if (hack_q) begin
                  tx_q   <= mem_rd[6:0];
                  pull_q <= ~mem_rd[7];
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              default: state_q <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end

  assign sda_pull_o = pull_q;

  // R12
  pull_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> $past(scl_fall));

  // R5
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_pull_o);

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_p && data_q && !busy) |=> busy);

  // R10
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt_q <= 4'd8);
endmodule

// File: tb/test_serial_mem_target.sv
`timescale 1ns/1ps
module test_serial_mem_target;
  localparam int BUSY = 1500;
  localparam int Q    = 10;
  localparam logic [2:0] SEL = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic hsda = 1'b1;
  logic wp = 1'b0;
  logic pull;
  logic sda_line;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_line = hsda & ~pull;

  serial_mem_target #(.BUSY_CYC(BUSY)) i_serial_mem_target (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .sel_i      (SEL),
    .wp_i       (wp),
    .sda_pull_o (pull)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bstart();
    hsda = 1'b1; wt(Q); scl = 1'b1; wt(Q);
    hsda = 1'b0; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bstop();
    hsda = 1'b0; wt(Q); scl = 1'b1; wt(Q); hsda = 1'b1; wt(Q);
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      hsda = b[i]; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
    end
    hsda = 1'b1; wt(Q); scl = 1'b1; wt(Q);
    ack = ~sda_line;
    wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic rx_byte(input logic host_ack, output logic [7:0] b);
    hsda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl = 1'b1; wt(Q); b[i] = sda_line; wt(Q); scl = 1'b0; wt(Q);
    end
    hsda = ~host_ack; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
    hsda = 1'b1;
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {4'b1010, SEL, rd};
  endfunction

  task automatic wr(input int a, input int n, input logic [7:0] b0,
                    input logic [7:0] b1, input logic [7:0] b2);
    logic ack;
    logic [7:0] d [3];
    d[0] = b0; d[1] = b1; d[2] = b2;
    bstart();
    tx_byte(dev(1'b0), ack); chk("R2 write device ack", ack, 1);
    tx_byte(8'(a >> 8), ack); chk("R3 high address ack", ack, 1);
    tx_byte(8'(a), ack);      chk("R3 low address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      tx_byte(d[i], ack); chk("R4 data ack", ack, 1);
    end
    bstop();
    wt(BUSY + 200);
  endtask

  task automatic rd(input int a, input int n, output logic [7:0] r0,
                    output logic [7:0] r1, output logic [7:0] r2);
    logic ack;
    logic [7:0] d [3];
    bstart();
    tx_byte(dev(1'b0), ack);
    tx_byte(8'(a >> 8), ack);
    tx_byte(8'(a), ack);
    bstart();
    tx_byte(dev(1'b1), ack); chk("R9 read device ack", ack, 1);
    for (int i = 0; i < n; i++) rx_byte(i != n - 1, d[i]);
    wt(2);
    chk("R10 released after host nack", pull, 0);
    bstop();
    r0 = d[0]; r1 = d[1]; r2 = d[2];
  endtask

  task automatic t_reset();
    wt(5);
    chk("R1 idle after reset", pull, 0);
  endtask

  task automatic t_mismatch();
    logic ack;
    bstart(); tx_byte({4'b1010, 3'b000, 1'b0}, ack); bstop();
    chk("R2 select mismatch nack", ack, 0);
    bstart(); tx_byte({4'b1011, SEL, 1'b1}, ack); bstop();
    chk("R2 tag mismatch nack", ack, 0);
    chk("R1 idle after mismatch", pull, 0);
  endtask

  task automatic t_byte_rw();
    logic [7:0] r0, r1, r2;
    wr(16'h0123, 1, 8'h5A, 8'h00, 8'h00);
    rd(16'h0123, 1, r0, r1, r2);
    chk("R9 random read of byte write", r0, 8'h5A);
  endtask

  task automatic t_poll();
    logic ack;
    logic [7:0] r;
    bstart();
    tx_byte(dev(1'b0), ack); tx_byte(8'h02, ack); tx_byte(8'h00, ack);
    tx_byte(8'h77, ack);
    bstop();
    bstart(); tx_byte(dev(1'b0), ack); bstop();
    chk("R5 nack during busy window", ack, 0);
    wt(BUSY + 200);
    bstart(); tx_byte(dev(1'b1), ack);
    chk("R5 ack after busy window", ack, 1);
    rx_byte(1'b0, r); bstop();
  endtask

  task automatic t_page_roll();
    logic [7:0] r0, r1, r2;
    wr(16'h007D, 1, 8'hA1, 8'h00, 8'h00);
    wr(16'h007E, 3, 8'h11, 8'h22, 8'h33);
    rd(16'h007D, 3, r0, r1, r2);
    chk("R7 untouched neighbour kept", r0, 8'hA1);
    chk("R4 first page byte", r1, 8'h11);
    chk("R4 last page byte", r2, 8'h22);
    rd(16'h0040, 1, r0, r1, r2);
    chk("R6 wrapped to page start", r0, 8'h33);
    rd(16'h0080, 1, r0, r1, r2);
    chk("R6 next page not written", r0 == 8'h33, 0);
  endtask

  task automatic t_wp();
    logic [7:0] r0, r1, r2;
    wp = 1'b1;
    wr(16'h0123, 1, 8'hEE, 8'h00, 8'h00);
    wp = 1'b0;
    rd(16'h0123, 1, r0, r1, r2);
    chk("R8 protected byte unchanged", r0, 8'h5A);
  endtask

  task automatic t_addr_only();
    logic ack;
    logic [7:0] r;
    bstart();
    tx_byte(dev(1'b0), ack); tx_byte(8'h01, ack); tx_byte(8'h23, ack);
    bstop();
    bstart(); tx_byte(dev(1'b1), ack);
    chk("R11 no busy after address-only write", ack, 1);
    rx_byte(1'b0, r); bstop();
    chk("R11 current address read", r, 8'h5A);
  endtask

  task automatic t_wrap();
    logic [7:0] r0, r1, r2;
    wr(16'h0000, 1, 8'hC3, 8'h00, 8'h00);
    wr(16'h07FF, 1, 8'h3C, 8'h00, 8'h00);
    rd(16'h07FF, 2, r0, r1, r2);
    chk("R10 last array byte", r0, 8'h3C);
    chk("R10 sequential wrap to zero", r1, 8'hC3);
  endtask

  initial begin
    wt(4);
    rst_n = 1'b1;
    t_reset();
    t_mismatch();
    t_byte_rw();
    t_poll();
    t_page_roll();
    t_wp();
    t_addr_only();
    t_wrap();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule